// File: doc/BRIEF.md
# Programmable Eight-Line Interrupt Controller Port

This block is an eight-input interrupt controller with a byte-wide register port. The port has two addresses. Software sets it up with a short initialization sequence that may skip steps. After that, commands written to the low address end interrupts, rotate priorities and change read and mask modes. Inputs are edge sensitive. A rising edge latches a request. The block raises `int_req` when the best unmasked request outranks everything in service.

The host has two ways to take the winning line. It can pulse `ack`, which loads `vec` with the programmed vector base plus the line number. It can also arm poll mode and read the port, which returns a flag and the line number. Either way the winner moves from request to in-service. In auto-end mode it is retired at once instead. Priority is a ring of eight lines. A rotation pointer names the line that currently ranks highest.

Top module: `intc_prog_port`

## Requirements
- R1: A write to address 0 with bit 4 set clears the mask, request, in-service, rotation pointer, vector base, read select, poll and all modes, and enters the state that expects the vector base.
- R2: In that state a write to address 1 stores the vector base with bits 2..0 forced to zero. The next state depends on bit 1 (single) and bit 0 (fourth word needed) of the starting write. Single without fourth word returns to idle. Single with fourth word goes to the options state. Without single it goes to the cascade state.
- R3: In the cascade state a write to address 1 is consumed. It leads to the options state if a fourth word is needed, else to idle. In the options state bit 4 selects special fully nested mode, bit 1 selects auto-end, and the next state is idle.
- R4: In idle a write to address 1 loads the mask register, and a non-poll read of address 1 returns it.
- R5: A write to address 0 with bit 4 clear and bit 3 set is a control word. If bit 6 is set, bit 5 enables special mask mode, in which masked in-service lines are left out of the priority comparison.
- R6: A rising input edge latches a request bit. `int_req` is high when the highest-ranked unmasked request outranks the highest-ranked in-service line. Rank starts at the rotation pointer (line 0 after reset) and proceeds upward modulo 8.
- R7: On `ack` with a winner, `vec` becomes base plus winner line, the request bit clears, and the in-service bit sets. With no winner, `vec` is base plus 7 and no state changes.
- R8: Control word bit 2 arms poll. The next read from either address acknowledges the winner as in R7 and returns 0x80 OR the line number, or returns 0 with no winner. That read disarms poll.
- R9: Reads have one cycle of latency. Control word bit 1 makes bit 0 select what address 0 returns: 1 gives in-service, 0 gives request (the default after R1).
- R10: Command code 1 (address 0 bits 7..5, bits 4 and 3 clear) clears the highest-ranked in-service bit. Code 5 does the same and moves the rotation pointer to that line plus 1.
- R11: Code 3 clears the in-service bit named by bits 2..0. Code 7 does that and sets the pointer to that line plus 1. Code 6 sets the pointer to bits 2..0 plus 1, modulo 8. Code 2 changes nothing.
- R12: In auto-end mode an acknowledge does not set the in-service bit. After code 4 (undone by code 0), each such acknowledge also moves the pointer to the acknowledged line plus 1.
- R13: In special fully nested mode the in-service bit of line 2 is left out of the priority comparison, so a new request on line 2 can be raised again while line 2 is in service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq_in | input | NLINES | Interrupt request inputs, rising-edge sensitive |
| int_req | output | 1 | Interrupt pending towards the host |
| ack | input | 1 | Acknowledge strobe |
| vec | output | 8 | Vector captured on acknowledge |
| vec_base | output | 8 | Programmed vector base |

## Verification
Some conditions are hard to reach from the ports. One is a line that is already in service and gets asked to preempt itself (R13). Another is a masked in-service line that must stop blocking lower lines (R5). In both, the bench first acknowledges the line, then drops and raises the input again so a fresh edge is latched. Only then does it compare `int_req` with and without the mode bit. The rotation commands can only be observed through which line wins next. So each pointer value is swept, all eight inputs are raised, and the acknowledged vector is checked against the ring order.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_OPT  = 2'd3
  } seq_state_t;

  typedef enum logic [2:0] {
    CMD_RAEOI_OFF = 3'd0,
    CMD_EOI       = 3'd1,
    CMD_NOP       = 3'd2,
    CMD_SEOI      = 3'd3,
    CMD_RAEOI_ON  = 3'd4,
    CMD_REOI      = 3'd5,
    CMD_SETPRI    = 3'd6,
    CMD_RSEOI     = 3'd7
  } cmd_t;
endpackage

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       single_d,
  input  logic       need4_d,
  input  logic       step,
  output seq_state_t st_q
);
  logic single_q;
  logic need4_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SEQ_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else if (start) begin
      st_q     <= SEQ_BASE;
      single_q <= single_d;
      need4_q  <= need4_d;
    end else if (step) begin
      unique case (st_q)
        SEQ_BASE: st_q <= single_q ? (need4_q ? SEQ_OPT : SEQ_IDLE) : SEQ_CASC;
        SEQ_CASC: st_q <= need4_q ? SEQ_OPT : SEQ_IDLE;
        SEQ_OPT:  st_q <= SEQ_IDLE;
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] rot,
  output logic          valid,
  output logic [IW-1:0] pos
);
  logic [N-1:0] rv;

  // rv[i] is the line that ranks i-th, counting from the rotation pointer
  assign rv    = (req >> rot) | (req << (N - int'(rot)));
  assign valid = |req;

  always_comb begin
    pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rv[i]) pos = IW'(i);
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core #(
  parameter int N         = 8,
  parameter int IW        = 3,
  parameter int CASC_LINE = 2,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [N-1:0]  irq_in,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_d,
  input  logic          opt_we,
  input  logic          sfnm_d,
  input  logic          aeoi_d,
  input  logic          smm_we,
  input  logic          smm_d,
  input  logic          raeoi_we,
  input  logic          raeoi_d,
  input  logic [N-1:0]  isr_clr,
  input  logic          rot_we,
  input  logic [IW-1:0] rot_d,
  input  logic          ack_req,
  output logic [N-1:0]  irr_q,
  output logic [N-1:0]  isr_q,
  output logic [N-1:0]  imr_q,
  output logic          win_valid,
  output logic [IW-1:0] win_line,
  output logic          top_valid,
  output logic [IW-1:0] top_line
);
  localparam logic [N-1:0] CASC_BIT = IS_MASTER ? (N'(1) << CASC_LINE) : '0;

  logic [N-1:0]  last_q;
  logic [IW-1:0] rot_q;
  logic          smm_q, sfnm_q, aeoi_q, raeoi_q;

  logic [N-1:0]  req_vec, cmp_vec, ack_oh;
  logic          req_v, cur_v, ack_fire;
  logic [IW-1:0] req_pos, cur_pos, top_pos;

  assign req_vec = irr_q & ~imr_q;
  assign cmp_vec = isr_q & (smm_q ? ~imr_q : '1) & (sfnm_q ? ~CASC_BIT : '1);

  intc_prio_pick #(.N(N), .IW(IW)) u_req (.req(req_vec), .rot(rot_q), .valid(req_v),     .pos(req_pos));
  intc_prio_pick #(.N(N), .IW(IW)) u_cur (.req(cmp_vec), .rot(rot_q), .valid(cur_v),     .pos(cur_pos));
  intc_prio_pick #(.N(N), .IW(IW)) u_top (.req(isr_q),   .rot(rot_q), .valid(top_valid), .pos(top_pos));

  assign win_valid = req_v && (!cur_v || (req_pos < cur_pos));
  assign win_line  = req_pos + rot_q;
  assign top_line  = top_pos + rot_q;
  assign ack_fire  = ack_req && win_valid;
  assign ack_oh    = ack_fire ? (N'(1) << win_line) : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      irr_q   <= '0;
      isr_q   <= '0;
      imr_q   <= '0;
      last_q  <= '0;
      rot_q   <= '0;
      smm_q   <= 1'b0;
      sfnm_q  <= 1'b0;
      aeoi_q  <= 1'b0;
      raeoi_q <= 1'b0;
    end else begin
      last_q <= irq_in;
      irr_q  <= (irr_q | (irq_in & ~last_q)) & ~ack_oh;
      isr_q  <= (isr_q & ~isr_clr) | (aeoi_q ? '0 : ack_oh);
      if (mask_we)  imr_q   <= mask_d;
      if (smm_we)   smm_q   <= smm_d;
      if (raeoi_we) raeoi_q <= raeoi_d;
      if (opt_we) begin
        sfnm_q <= sfnm_d;
        aeoi_q <= aeoi_d;
      end
      if (rot_we)                             rot_q <= rot_d;
      else if (ack_fire && aeoi_q && raeoi_q) rot_q <= win_line + IW'(1);
    end
  end
endmodule

// File: rtl/intc_prog_port.sv
module intc_prog_port
  import intc_pkg::*;
#(
  parameter int NLINES    = 8,
  parameter int CASC_LINE = 2,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [NLINES-1:0] irq_in,
  output logic              int_req,
  input  logic              ack,
  output logic [7:0]        vec,
  output logic [7:0]        vec_base
);
  localparam int IW = $clog2(NLINES);

  seq_state_t        st_w;
  logic              wr0, wr1, init_go, ctl_go, cmd_go, poll_rd;
  cmd_t              code;
  logic [NLINES-1:0] irr_w, isr_w, imr_w, isr_clr;
  logic              win_valid, top_valid;
  logic [IW-1:0]     win_line, top_line, rot_d;
  logic              rot_we, raeoi_we;
  logic              poll_q, rsel_q;
  logic [7:0]        base_q;

  assign wr0     = wr_en && !addr;
  assign wr1     = wr_en && addr;
  assign init_go = wr0 && wdata[4];
  assign ctl_go  = wr0 && !wdata[4] && wdata[3];
  assign cmd_go  = wr0 && !wdata[4] && !wdata[3];
  assign code    = cmd_t'(wdata[7:5]);
  assign poll_rd = rd_en && poll_q;

  intc_init_seq u_seq (
    .clk(clk), .rst(rst), .start(init_go),
    .single_d(wdata[1]), .need4_d(wdata[0]),
    .step(wr1), .st_q(st_w)
  );

  always_comb begin
    isr_clr  = '0;
    rot_we   = 1'b0;
    rot_d    = '0;
    raeoi_we = 1'b0;
    if (cmd_go) begin
      unique case (code)
        CMD_RAEOI_OFF, CMD_RAEOI_ON: raeoi_we = 1'b1;
        CMD_EOI, CMD_REOI: begin
          if (top_valid) begin
            isr_clr = NLINES'(1) << top_line;
            rot_we  = (code == CMD_REOI);
            rot_d   = top_line + IW'(1);
          end
        end
        CMD_SEOI: isr_clr = NLINES'(1) << wdata[IW-1:0];
        CMD_SETPRI: begin
          rot_we = 1'b1;
          rot_d  = wdata[IW-1:0] + IW'(1);
        end
        CMD_RSEOI: begin
          isr_clr = NLINES'(1) << wdata[IW-1:0];
          rot_we  = 1'b1;
          rot_d   = wdata[IW-1:0] + IW'(1);
        end
        default: ;
      endcase
    end
  end

  intc_core #(.N(NLINES), .IW(IW), .CASC_LINE(CASC_LINE), .IS_MASTER(IS_MASTER)) u_core (
    .clk(clk), .rst(rst), .clr(init_go), .irq_in(irq_in),
    .mask_we(wr1 && st_w == SEQ_IDLE), .mask_d(wdata[NLINES-1:0]),
    .opt_we(wr1 && st_w == SEQ_OPT), .sfnm_d(wdata[4]), .aeoi_d(wdata[1]),
    .smm_we(ctl_go && wdata[6]), .smm_d(wdata[5]),
    .raeoi_we(raeoi_we), .raeoi_d(wdata[7]),
    .isr_clr(isr_clr), .rot_we(rot_we), .rot_d(rot_d),
    .ack_req(ack || poll_rd),
    .irr_q(irr_w), .isr_q(isr_w), .imr_q(imr_w),
    .win_valid(win_valid), .win_line(win_line),
    .top_valid(top_valid), .top_line(top_line)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_q <= 1'b0;
      rsel_q <= 1'b0;
      base_q <= '0;
      rdata  <= '0;
      vec    <= '0;
    end else begin
      if (init_go) begin
        poll_q <= 1'b0;
        rsel_q <= 1'b0;
        base_q <= '0;
      end else begin
        if (ctl_go && wdata[2]) poll_q <= 1'b1;
        else if (rd_en)         poll_q <= 1'b0;
        if (ctl_go && wdata[1]) rsel_q <= wdata[0];
        if (wr1 && st_w == SEQ_BASE) base_q <= {wdata[7:IW], {IW{1'b0}}};
      end
      if (rd_en) begin
        if (poll_q)    rdata <= win_valid ? (8'h80 | 8'(win_line)) : 8'h00;
        else if (addr) rdata <= 8'(imr_w);
        else           rdata <= rsel_q ? 8'(isr_w) : 8'(irr_w);
      end
      if (ack) vec <= base_q | 8'(win_valid ? win_line : IW'(NLINES - 1));
    end
  end

  assign int_req  = win_valid;
  assign vec_base = base_q;
endmodule

// File: rtl/intc_prog_port_chk.sv
module intc_prog_port_chk
  import intc_pkg::*;
#(
  parameter int N = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       ack,
  input logic [7:0] vec,
  input logic [7:0] vec_base,
  input logic       int_req,
  input seq_state_t seq_st,
  input logic [N-1:0] imr,
  input logic       poll_armed
);
  localparam int IW = $clog2(N);

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (vec_base == 8'h00 && !int_req)); // R1

  AST_BASE_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && seq_st == SEQ_BASE) |=>
      (vec_base[7:IW] == $past(wdata[7:IW]) && vec_base[IW-1:0] == '0)); // R2

  AST_MASK_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr && !poll_armed) |=> (rdata == 8'($past(imr)))); // R4

  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (rst)
    (ack && !int_req) |=> (vec == ($past(vec_base) | 8'(N - 1)))); // R7

  AST_POLL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll_armed && !int_req) |=> (rdata == 8'h00)); // R8

  AST_POLL_HIT: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll_armed && int_req) |=> rdata[7]); // R8

  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(wr_en && !addr && !wdata[4] && wdata[3] && wdata[2])) |=> !poll_armed); // R8
endmodule

bind intc_prog_port intc_prog_port_chk #(.N(NLINES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .ack(ack), .vec(vec), .vec_base(vec_base),
  .int_req(int_req), .seq_st(st_w), .imr(imr_w), .poll_armed(poll_q)
);

// File: tb/intc_prog_port_bench.sv
module intc_prog_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [N-1:0] irq = '0;
  logic [7:0] rdata, vec, vec_base;
  logic int_req;
  int errs = 0, checks = 0;
  logic [7:0] v;

  always #(CLK_PERIOD / 2) clk = ~clk;

  intc_prog_port u_intc_prog_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq), .int_req(int_req),
    .ack(ack), .vec(vec), .vec_base(vec_base)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_ack(output logic [7:0] d);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0; d = vec;
  endtask

  task automatic set_irq(input logic [N-1:0] p);
    @(negedge clk); irq = p;
    @(negedge clk);
  endtask

  task automatic init(input bit single, input bit need4, input logic [7:0] base, input logic [7:0] opt);
    wr(1'b0, 8'h10 | (8'(single) << 1) | 8'(need4));
    wr(1'b1, base);
    if (!single) wr(1'b1, 8'h00);
    if (need4) wr(1'b1, opt);
  endtask

  function automatic int pick(input logic [N-1:0] m, input int rot);
    for (int k = 0; k < N; k++) begin
      if (m[(k + rot) % N]) return (k + rot) % N;
    end
    return N;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired, all requirements unfinished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R1 reset int_req", int_req, 0);
    chk("R1 reset base", vec_base, 0);
    rd(1'b1, v); chk("R4 reset mask", v, 0);
    rd(1'b0, v); chk("R9 reset request", v, 0);

    // R1: a second init wipes mask, in-service, select
    init(1, 0, 8'h18, 0);
    set_irq(8'h01); do_ack(v);
    wr(1'b0, 8'h0B); wr(1'b1, 8'hF0);
    set_irq(8'h00);
    init(1, 0, 8'h28, 0);
    chk("R1 base reload", vec_base, 8'h28);
    rd(1'b1, v); chk("R1 mask cleared", v, 0);
    rd(1'b0, v); chk("R1 request view", v, 0);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R1 in-service cleared", v, 0);

    // R2/R3: sequence skipping for all flag combinations
    for (int s = 0; s < 2; s++) begin
      for (int f = 0; f < 2; f++) begin
        for (int bi = 0; bi < 4; bi++) begin
          logic [7:0] b;
          b = 8'(bi * 8'h55 + 3);
          init(s[0], f[0], b, 8'h00);
          chk("R2 base aligned", vec_base, b & 8'hF8);
          wr(1'b1, 8'h5A ^ b); rd(1'b1, v);
          chk("R3 back in idle", v, 8'h5A ^ b);
        end
      end
    end

    // R4: all mask values
    init(1, 0, 8'h20, 0);
    for (int m = 0; m < 256; m++) begin
      wr(1'b1, 8'(m)); rd(1'b1, v); chk("R4 mask readback", v, m);
    end

    // R6/R7/R9: every request pattern, fixed priority
    for (int p = 1; p < 256; p++) begin
      int l;
      set_irq(8'h00);
      init(1, 0, 8'h40, 0);
      set_irq(8'(p));
      chk("R6 pending", int_req, 1);
      l = pick(8'(p), 0);
      do_ack(v); chk("R7 vector", v, 8'h40 + l);
      chk("R6 lower lines held off", int_req, 0);
      rd(1'b0, v); chk("R9 request view", v, 8'(p) & ~(8'h01 << l));
      wr(1'b0, 8'h0B); rd(1'b0, v); chk("R9 in-service view", v, 8'h01 << l);
    end

    // R6/R7: every mask against all lines, including spurious
    for (int m = 0; m < 256; m++) begin
      int l;
      set_irq(8'h00);
      init(1, 0, 8'h80, 0);
      wr(1'b1, 8'(m));
      set_irq(8'hFF);
      chk("R6 masked pending", int_req, m != 255);
      l = pick(~8'(m), 0);
      do_ack(v); chk("R7 masked vector", v, (l == N) ? 8'h87 : 8'h80 + l);
    end

    // R13: special fully nested lets line 2 re-raise
    set_irq(8'h00); init(1, 1, 8'h08, 8'h10);
    set_irq(8'h04); do_ack(v); set_irq(8'h00); set_irq(8'h04);
    chk("R13 nested on", int_req, 1);
    set_irq(8'h00); init(1, 1, 8'h08, 8'h00);
    set_irq(8'h04); do_ack(v); set_irq(8'h00); set_irq(8'h04);
    chk("R13 nested off", int_req, 0);

    // R5: special mask mode
    set_irq(8'h00); init(1, 0, 8'h00, 0);
    set_irq(8'h04); do_ack(v);
    wr(1'b1, 8'h04); set_irq(8'h24);
    chk("R5 blocked without special mask", int_req, 0);
    wr(1'b0, 8'h68); chk("R5 special mask on", int_req, 1);
    wr(1'b0, 8'h48); chk("R5 special mask off", int_req, 0);

    // R10: non-specific end and rotating end
    set_irq(8'h00); init(1, 0, 8'h10, 0);
    set_irq(8'h10); do_ack(v);
    set_irq(8'h12); do_ack(v); chk("R10 setup vector", v, 8'h11);
    wr(1'b0, 8'h20); wr(1'b0, 8'h0B); rd(1'b0, v);
    chk("R10 clears top in-service", v, 8'h10);
    wr(1'b0, 8'hA0); rd(1'b0, v); chk("R10 rotating end clears", v, 8'h00);
    set_irq(8'h00); set_irq(8'h41); do_ack(v);
    chk("R10 pointer moved to 5", v, 8'h16);

    // R11: set-priority sweep, specific ends, nop
    for (int k = 0; k < N; k++) begin
      int w, w2, w3;
      set_irq(8'h00); init(1, 0, 8'h30, 0);
      wr(1'b0, 8'hC0 | 8'(k));
      set_irq(8'hFF);
      w = (k + 1) % N;
      do_ack(v); chk("R11 set priority", v, 8'h30 + w);
      wr(1'b0, 8'h0B);
      wr(1'b0, 8'h60 | 8'((w + 1) % N)); rd(1'b0, v);
      chk("R11 specific end other line", v, 8'h01 << w);
      wr(1'b0, 8'h40); rd(1'b0, v); chk("R11 code 2 no effect", v, 8'h01 << w);
      wr(1'b0, 8'h60 | 8'(w)); rd(1'b0, v); chk("R11 specific end", v, 0);
      w2 = (w + 1) % N;
      do_ack(v); chk("R11 next winner", v, 8'h30 + w2);
      wr(1'b0, 8'hE0 | 8'(w2)); rd(1'b0, v); chk("R11 rotating specific clears", v, 0);
      w3 = pick(8'hFF & ~(8'h01 << w) & ~(8'h01 << w2), w2 + 1);
      do_ack(v); chk("R11 rotating specific pointer", v, 8'h30 + w3);
    end

    // R12: auto-end with and without rotation
    set_irq(8'h00); init(1, 1, 8'h50, 8'h02);
    set_irq(8'h08); do_ack(v); chk("R12 auto-end vector", v, 8'h53);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R12 no in-service", v, 0);
    wr(1'b0, 8'h80);
    set_irq(8'h00); set_irq(8'h09); do_ack(v); chk("R12 first winner", v, 8'h50);
    set_irq(8'h08); set_irq(8'h09); do_ack(v); chk("R12 rotated winner", v, 8'h53);

    // R8: poll
    set_irq(8'h00); init(1, 0, 8'h60, 0);
    set_irq(8'h20);
    wr(1'b0, 8'h0C); rd(1'b0, v); chk("R8 poll hit", v, 8'h85);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R8 poll acknowledged", v, 8'h20);
    wr(1'b1, 8'h11);
    wr(1'b0, 8'h0C); rd(1'b1, v); chk("R8 poll empty", v, 0);
    rd(1'b1, v); chk("R8 poll disarmed", v, 8'h11);

    finish_run();
  end
endmodule